// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block generates the word address for a four-beat burst in a synchronous SRAM controller. When a burst starts, the controller pulses a load strobe together with the full starting address. The block keeps the upper address bits unchanged for the whole burst. It derives the low two bits from the captured start bits and an internal beat counter. Each advance pulse moves to the next beat. The sequence wraps inside the aligned four-word block and returns to the start address after the fourth beat.

Two orders are supported, and the mode input picks one at load time. Linear order adds the beat count to the start bits, modulo four. Interleaved order XORs the beat count into the start bits. The captured mode resets to interleaved through the parameter `MODE_RST`, so an undriven or pulled-up mode line gives interleaved behaviour. A last-beat flag marks the fourth beat.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, `addr_o` is all zeros and `last_o` is 0.
- R2: In the cycle after `load_i` is high, `addr_o` equals the `start_addr_i` value that was presented with the load.
- R3: When `mode_i` was 0 at load (linear), each advance sets `addr_o[1:0]` to its previous value plus one, modulo four. Starting from 01 this gives 01, 10, 11, 00.
- R4: When `mode_i` was 1 at load (interleaved), `addr_o[1:0]` equals the start bits XOR the number of advances since the load, modulo four. Starting from 01 this gives 01, 00, 11, 10.
- R5: `last_o` is 1 exactly when three advances, modulo four, have occurred since the last load.
- R6: An advance while `last_o` is 1 returns `addr_o[1:0]` to the start bits and clears `last_o`.
- R7: When `load_i` and `adv_i` are high in the same cycle, the load wins. The next cycle shows the new start address with `last_o` at 0.
- R8: `mode_i` is sampled only when `load_i` is high. Changes to `mode_i` during a burst do not change the order.
- R9: `addr_o[ADDR_W-1:2]` holds the upper bits captured at load, through every advance, until the next load.
- R10: In a cycle with neither `load_i` nor `adv_i`, `addr_o` and `last_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Begin a burst at `start_addr_i` |
| start_addr_i | input | ADDR_W | Starting word address of the burst |
| adv_i | input | 1 | Step to the next beat |
| mode_i | input | 1 | Order select at load: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current burst word address |
| last_o | output | 1 | High on the fourth beat |

## Verification
A load and an advance can arrive in the same cycle. The load must win. This case matters most when the old burst sits on its last beat, because a wrap that leaks through would show the old start bits or a high last flag. The bench drives both strobes together at several beat positions, including the last beat, in each mode and in a long random stretch. A behavioural reference model predicts every output. A wrong priority shows up as a mismatch on `addr_o` or `last_o` in the following cycle.

// File: rtl/burst_seq_pkg.sv
// Shared types for the burst address sequencer.
// Assumes: order select is a single bit; 0 means linear, 1 means interleaved.
package burst_seq_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_beat_ctr.sv
// Beat counter for one burst.
// Clears on clear_i, which has priority over step_i, and wraps modulo 2**BEAT_W.
// Assumes: clear_i and step_i are synchronous single-cycle strobes.
module burst_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    output logic [BEAT_W-1:0] beat_o,
    output logic              last_o
);
    localparam logic [BEAT_W-1:0] BEAT_LAST = {BEAT_W{1'b1}};
    localparam logic [BEAT_W-1:0] BEAT_ONE  = {{(BEAT_W-1){1'b0}}, 1'b1};

    logic [BEAT_W-1:0] beat_q;

    // Count beats; clear wins over step; natural wrap at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)       beat_q <= '0;
        else if (clear_i) beat_q <= '0;
        else if (step_i)  beat_q <= beat_q + BEAT_ONE;
    end

    assign beat_o = beat_q;
    assign last_o = (beat_q == BEAT_LAST);

    // R7: a clear beats a simultaneous step
    a_r7_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && step_i) |=> (beat_o == '0));

    // R6: stepping from the last beat wraps to zero
    a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && step_i && !clear_i) |=> (beat_o == '0 && !last_o));

    // R10: with no strobe the count holds
    a_r10_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !step_i) |=> $stable(beat_o));
endmodule

// File: rtl/burst_ctx_reg.sv
// Per-burst context: captures the start low bits, the upper bits and the order at load.
// Assumes: the reset value of the order models a pulled-up (interleaved) mode line.
module burst_ctx_reg
    import burst_seq_pkg::*;
#(
    parameter int   ADDR_W   = 17,
    parameter int   BEAT_W   = 2,
    parameter logic MODE_RST = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic                     mode_i,
    output logic [BEAT_W-1:0]        start_low_o,
    output logic [ADDR_W-BEAT_W-1:0] upper_o,
    output burst_order_e             order_o
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic [BEAT_W-1:0]  start_low_q;
    logic [UPPER_W-1:0] upper_q;
    burst_order_e       order_q;

    // Capture the burst context on load; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_low_q <= '0;
            upper_q     <= '0;
            order_q     <= burst_order_e'(MODE_RST);
        end else if (load_i) begin
            start_low_q <= addr_i[BEAT_W-1:0];
            upper_q     <= addr_i[ADDR_W-1:BEAT_W];
            order_q     <= burst_order_e'(mode_i);
        end
    end

    assign start_low_o = start_low_q;
    assign upper_o     = upper_q;
    assign order_o     = order_q;

    // R8: the order changes only on a load
    a_r8_order_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(order_o));

    // R9: the upper bits change only on a load
    a_r9_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(upper_o));
endmodule

// File: rtl/burst_order_map.sv
// Maps the start bits and the beat count to the current low address bits.
// Linear order adds them; interleaved order XORs them, bit by bit.
// Assumes: both operands share the BEAT_W width; the result wraps inside the block.
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  burst_order_e      order_i,
    output logic [BEAT_W-1:0] low_o
);
    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    // Linear: add with the carry dropped, so the count wraps in the aligned block.
    assign lin_low = start_i + beat_i;

    // Interleaved: one XOR per address bit.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_low[b] = start_i[b] ^ beat_i[b];
    end

    // Pick the order that was captured for this burst.
    always_comb begin
        low_o = (order_i == ORD_LINEAR) ? lin_low : ilv_low;
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Burst address sequencer, top level.
// A load captures the start address and the order. Each advance steps the low
// BEAT_W bits through the burst and keeps the upper bits fixed.
// Assumes: strobes are synchronous to clk; load has priority over advance.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int   ADDR_W   = 17,
    parameter int   BEAT_W   = 2,
    parameter logic MODE_RST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              adv_i,
    input  logic              mode_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    localparam int UPPER_W = ADDR_W - BEAT_W;
    localparam logic [BEAT_W-1:0] STEP_ONE = {{(BEAT_W-1){1'b0}}, 1'b1};

    logic [BEAT_W-1:0]  beat;
    logic [BEAT_W-1:0]  start_low;
    logic [UPPER_W-1:0] upper;
    logic [BEAT_W-1:0]  low;
    burst_order_e       order;

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load_i),
        .step_i  (adv_i),
        .beat_o  (beat),
        .last_o  (last_o)
    );

    burst_ctx_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .MODE_RST(MODE_RST)) u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .addr_i      (start_addr_i),
        .mode_i      (mode_i),
        .start_low_o (start_low),
        .upper_o     (upper),
        .order_o     (order)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .start_i (start_low),
        .beat_i  (beat),
        .order_i (order),
        .low_o   (low)
    );

    // Join the held upper bits with the mapped low bits.
    assign addr_o = {upper, low};

    // R2: a load shows the start address on the next cycle
    a_r2_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o == $past(start_addr_i) && !last_o));

    // R3: a linear advance adds one to the low bits
    a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && order == ORD_LINEAR)
        |=> (addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + STEP_ONE));

    // R4: an interleaved advance flips the same low bits that the beat count flips
    a_r4_ilv_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && order == ORD_INTERLEAVE)
        |=> ((addr_o[BEAT_W-1:0] ^ $past(addr_o[BEAT_W-1:0])) == (beat ^ $past(beat))));

    // R6: an advance on the last beat returns to the start bits
    a_r6_wrap_start: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && adv_i && !load_i) |=> (addr_o[BEAT_W-1:0] == start_low));

    // R10: with no strobe the output holds
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> ($stable(addr_o) && $stable(last_o)));
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
    localparam int ADDR_W = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_i = 1'b0;
    logic [ADDR_W-1:0] start_addr_i = '0;
    logic              adv_i = 1'b0;
    logic              mode_i = 1'b1;
    logic [ADDR_W-1:0] addr_o;
    logic              last_o;

    int total = 0;
    int bad = 0;
    bit started = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    int m_start = 0;
    int m_upper = 0;
    int m_beat = 0;
    int m_mode = 1;

    always #2 clk = ~clk;

    burst_addr_seq u_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_addr_i(start_addr_i),
        .adv_i(adv_i), .mode_i(mode_i), .addr_o(addr_o), .last_o(last_o)
    );

    // behavioural model, updated on each rising edge
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_start = 0; m_upper = 0; m_beat = 0; m_mode = 1;
        end else if (load_i) begin
            m_start = int'(start_addr_i) % 4;
            m_upper = int'(start_addr_i) / 4;
            m_mode  = int'(mode_i);
            m_beat  = 0;
        end else if (adv_i) begin
            m_beat = (m_beat + 1) % 4;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            int exp_low;
            int exp_last;
            exp_low  = (m_mode == 1) ? (m_start ^ m_beat) : ((m_start + m_beat) % 4);
            exp_last = (m_beat == 3) ? 1 : 0;
            total++;
            if (int'(addr_o[1:0]) != exp_low) begin
                bad++;
                $display("FAIL %s low bits actual=%0d expected=%0d", cur_req, addr_o[1:0], exp_low);
            end
            total++;
            if (int'(addr_o[ADDR_W-1:2]) != m_upper) begin
                bad++;
                $display("FAIL R9 upper bits actual=%0h expected=%0h", addr_o[ADDR_W-1:2], m_upper);
            end
            total++;
            if (int'(last_o) != exp_last) begin
                bad++;
                $display("FAIL R5 last flag actual=%0d expected=%0d", last_o, exp_last);
            end
        end
    end

    task automatic cyc(input bit l, input int a, input bit v, input bit m);
        load_i = l; start_addr_i = ADDR_W'(a); adv_i = v; mode_i = m;
        @(negedge clk);
    endtask

    task automatic burst(input int a, input bit m, input int advs);
        cyc(1'b1, a, 1'b0, m);
        for (int i = 0; i < advs; i++) cyc(1'b0, 0, 1'b1, ~m);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 0, 1'b0, 1'b0);

        // R2, R3: linear bursts from every start, including a wrap (R6)
        for (int s = 0; s < 4; s++) begin
            cur_req = "R3";
            burst(32'h1A5C4 + s, 1'b0, 5);
        end
        // R4: interleaved bursts from every start
        for (int s = 0; s < 4; s++) begin
            cur_req = "R4";
            burst(32'h0F3B0 + s, 1'b1, 5);
        end

        // R10: idle cycles between advances
        cur_req = "R10";
        cyc(1'b1, 32'h12345, 1'b0, 1'b1);
        repeat (3) cyc(1'b0, 32'h1FFFF, 1'b0, 1'b0);
        cyc(1'b0, 0, 1'b1, 1'b0);
        repeat (2) cyc(1'b0, 0, 1'b0, 1'b1);

        // R7: load with advance, on the last beat and mid-burst
        cur_req = "R7";
        burst(32'h00003, 1'b0, 3);
        cyc(1'b1, 32'h1FFFE, 1'b1, 1'b1);
        cyc(1'b0, 0, 1'b1, 1'b0);
        cyc(1'b1, 32'h00001, 1'b1, 1'b0);
        cyc(1'b0, 0, 1'b1, 1'b1);

        // R8: mode toggles mid-burst are ignored
        cur_req = "R8";
        cyc(1'b1, 32'h00002, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) cyc(1'b0, 0, 1'b1, i[0]);

        // R6, R9: long runs with many wraps
        cur_req = "R6";
        burst(32'h15551, 1'b1, 9);

        // mixed random stimulus
        cur_req = "R2";
        for (int i = 0; i < 400; i++)
            cyc(($urandom % 5) == 0, int'($urandom % (1 << ADDR_W)),
                ($urandom % 3) != 0, ($urandom % 2) == 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule